// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading page-table descriptors from memory. A requester hands it a 32-bit virtual address together with a write flag and a fetch flag. The block reads a first-level descriptor and, if that descriptor points to a second-level table, reads a second-level descriptor as well. It then reports one result: a physical address, a 3-bit permission code, a domain, a global flag and an execute-never flag, or a fault code in place of these.

When a mapping is used for the first time, its descriptor has the access flag clear. The walker sets the flag and writes the updated descriptor back to the address it was read from. It does this before it reports the result. Requests that arrive while a walk is in progress wait in a small in-order queue.

Memory is reached through one valid/ready request channel that carries both reads and writes, plus a read-response strobe. Only one memory access is outstanding at any time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `res_valid` are 0.
- R2: The first memory access of a walk is a read (`mem_req_we`=0) at address {`tbase`[17:0], vaddr[31:20], 2'b00}.
- R3: A first-level descriptor with bits[1:0]=2 and bit18=0 is a section. For a section:
  - the physical address is {desc[31:20], vaddr[19:0]};
  - the permission code is {desc[15], desc[11:10]};
  - execute-never is desc[4];
  - global is desc[17];
  - the domain is desc[8:5].
- R4: Three first-level cases end the walk with no further memory access:
  - bits[1:0]=0 reports fault code 1;
  - bits[1:0]=3 reports fault code 1;
  - bits[1:0]=2 with bit18=1 reports fault code 2.
  Fault code 0 means success.
- R5: A first-level descriptor with bits[1:0]=1 points to a table. The walker then reads address {desc[31:10], vaddr[19:12], 2'b00}.
- R6: For a valid second-level descriptor:
  - the permission code is {d[9], d[5:4]};
  - global is the inverse of d[11];
  - the domain comes from the first-level descriptor bits[8:5].
  - When bits[1:0]=1 (64 KB page), the physical address is {d[31:16], vaddr[15:0]} and execute-never is d[15].
  - When bit1=1 (4 KB page), the physical address is {d[31:12], vaddr[11:0]} and execute-never is d[0].
- R7: A second-level descriptor with bits[1:0]=0 reports fault code 3.
- R8: When the access flag is clear in a successful descriptor (section bit10, second-level bit4), the walker writes that descriptor back with the flag set, to the address it was read from, before the result. The reported permission code includes the set flag. When the flag is already set, no write occurs.
- R9: Accepted requests are walked in arrival order. Up to QDEPTH (4) requests wait while a walk is stalled, and `req_ready` is 0 while the queue is full.
- R10: A memory request holds its valid, address, direction and data stable until `mem_req_ready` is 1.
- R11: Each walk produces exactly one single-cycle `res_valid` pulse. `res_vaddr`, `res_write` and `res_fetch` on that pulse echo the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase | input | 18 | Translation table base, address bits [31:14] |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Queue can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is for a write access |
| req_fetch | input | 1 | Request is for an instruction fetch |
| mem_req_valid | output | 1 | Memory access valid |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Descriptor address |
| mem_req_wdata | output | 32 | Write-back descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read descriptor |
| res_valid | output | 1 | Result valid, one cycle |
| res_fcode | output | 2 | 0 ok, 1 first-level invalid/reserved, 2 supersection, 3 second-level invalid |
| res_vaddr | output | 32 | Echoed virtual address |
| res_write | output | 1 | Echoed write flag |
| res_fetch | output | 1 | Echoed fetch flag |
| res_paddr | output | 32 | Physical address |
| res_perm | output | 3 | Permission code |
| res_domain | output | 4 | Domain |
| res_global | output | 1 | Global mapping |
| res_xn | output | 1 | Execute-never |

## Verification
With memory always ready and a one-cycle read response, the timing is as follows:
- a section result appears four cycles after the request is accepted;
- each second-level read adds two cycles;
- each write-back adds one cycle.

Stalls on `mem_req_ready` stretch these figures by the stall length. The checks therefore do not count cycles. Instead, a monitor samples `res_valid` on the falling edge and logs each result, and a memory model logs every accepted access the same way. Each scenario waits for its own log entry and then compares the logged fields and the logged memory accesses with values derived from the requirements.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int QDEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [17:0] tbase,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_fetch,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        res_valid,
  output logic [1:0]  res_fcode,
  output logic [31:0] res_vaddr,
  output logic        res_write,
  output logic        res_fetch,
  output logic [31:0] res_paddr,
  output logic [2:0]  res_perm,
  output logic [3:0]  res_domain,
  output logic        res_global,
  output logic        res_xn
);
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW  = QAW + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_L1RD, S_L1WT, S_L1WB, S_L2RD, S_L2WT, S_L2WB, S_DONE
  } st_t;

  st_t st;

  logic [31:0]    q_va [QDEPTH];
  logic [QDEPTH-1:0] q_w, q_f;
  logic [QAW-1:0] wp, rp;
  logic [CW-1:0]  cnt;

  logic [31:0] va, d1, d2;
  logic        wr, fe, lvl2;
  logic [1:0]  fc;

  wire push = req_valid && req_ready;
  wire pop  = (st == S_IDLE) && (cnt != '0);

  assign req_ready = (cnt != CW'(QDEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        q_va[wp] <= req_vaddr;
        q_w[wp]  <= req_write;
        q_f[wp]  <= req_fetch;
        wp <= (wp == QAW'(QDEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == QAW'(QDEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  wire [31:0] l1a = {tbase, va[31:20], 2'b00};
  wire [31:0] l2a = {d1[31:10], va[19:12], 2'b00};
  wire        in2 = (st == S_L2RD) || (st == S_L2WB);

  assign mem_req_valid = (st == S_L1RD) || (st == S_L2RD) || (st == S_L1WB) || (st == S_L2WB);
  assign mem_req_we    = (st == S_L1WB) || (st == S_L2WB);
  assign mem_req_addr  = in2 ? l2a : l1a;
  assign mem_req_wdata = in2 ? d2 : d1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      va   <= '0;
      d1   <= '0;
      d2   <= '0;
      wr   <= 1'b0;
      fe   <= 1'b0;
      lvl2 <= 1'b0;
      fc   <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (pop) begin
          va   <= q_va[rp];
          wr   <= q_w[rp];
          fe   <= q_f[rp];
          fc   <= 2'd0;
          lvl2 <= 1'b0;
          st   <= S_L1RD;
        end
        S_L1RD: if (mem_req_ready) st <= S_L1WT;
        S_L1WT: if (mem_rsp_valid) begin
          case (mem_rsp_data[1:0])
            2'b01: begin
              d1 <= mem_rsp_data;
              st <= S_L2RD;
            end
            2'b10: begin
              if (mem_rsp_data[18]) begin
                fc <= 2'd2;
                st <= S_DONE;
              end else begin
                d1 <= mem_rsp_data | 32'h0000_0400;
                st <= mem_rsp_data[10] ? S_DONE : S_L1WB;
              end
            end
            default: begin
              fc <= 2'd1;
              st <= S_DONE;
            end
          endcase
        end
        S_L1WB: if (mem_req_ready) st <= S_DONE;
        S_L2RD: if (mem_req_ready) st <= S_L2WT;
        S_L2WT: if (mem_rsp_valid) begin
          if (mem_rsp_data[1:0] == 2'b00) begin
            fc <= 2'd3;
            st <= S_DONE;
          end else begin
            d2   <= mem_rsp_data | 32'h0000_0010;
            lvl2 <= 1'b1;
            st   <= mem_rsp_data[4] ? S_DONE : S_L2WB;
          end
        end
        S_L2WB: if (mem_req_ready) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire big = ~d2[1];

  assign res_valid  = (st == S_DONE);
  assign res_fcode  = fc;
  assign res_vaddr  = va;
  assign res_write  = wr;
  assign res_fetch  = fe;
  assign res_paddr  = !lvl2 ? {d1[31:20], va[19:0]} :
                      big   ? {d2[31:16], va[15:0]} : {d2[31:12], va[11:0]};
  assign res_perm   = lvl2 ? {d2[9], d2[5:4]} : {d1[15], d1[11:10]};
  assign res_domain = d1[8:5];
  assign res_global = lvl2 ? ~d2[11] : d1[17];
  assign res_xn     = !lvl2 ? d1[4] : (big ? d2[15] : d2[0]);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !mem_req_valid && !res_valid); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)); // R10
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R11
  AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !mem_req_valid); // R8
  AST_WB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> (in2 ? mem_req_wdata[4] : mem_req_wdata[10])); // R8
  AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(QDEPTH)); // R9
  AST_FAULT_END: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fcode != 2'd0 |-> !$past(mem_req_we)); // R4
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [17:0] tbase = 18'h20001;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid, res_write, res_fetch, res_global, res_xn;
  logic [1:0]  res_fcode;
  logic [31:0] res_vaddr, res_paddr;
  logic [2:0]  res_perm;
  logic [3:0]  res_domain;

  pt_walker i_pt_walker (.*);

  int tests = 0, fails = 0;

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // memory model: two programmed addresses plus a default word
  logic [31:0] a1 = '0, m1 = '0, a2 = '0, m2 = '0, mdef = 32'h0000_0402;
  logic        pend = 1'b0;
  logic [31:0] pend_d = '0;
  int nrd = 0, nwr = 0;
  logic [31:0] rd_log [8];
  logic [31:0] wa_log [8];
  logic [31:0] wd_log [8];

  always @(negedge clk) begin
    mem_rsp_valid <= pend;
    mem_rsp_data  <= pend_d;
    pend <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        wa_log[nwr % 8] = mem_req_addr;
        wd_log[nwr % 8] = mem_req_wdata;
        nwr++;
      end else begin
        rd_log[nrd % 8] = mem_req_addr;
        nrd++;
        pend   <= 1'b1;
        pend_d <= (mem_req_addr == a1) ? m1 : (mem_req_addr == a2) ? m2 : mdef;
      end
    end
  end

  // result monitor
  int nres = 0;
  logic [31:0] r_va [64];
  logic [31:0] r_pa [64];
  logic [1:0]  r_fc [64];
  logic [2:0]  r_pm [64];
  logic [3:0]  r_dm [64];
  logic        r_g [64];
  logic        r_x [64];
  logic        r_w [64];
  logic        r_f [64];

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      r_va[nres % 64] = res_vaddr;
      r_pa[nres % 64] = res_paddr;
      r_fc[nres % 64] = res_fcode;
      r_pm[nres % 64] = res_perm;
      r_dm[nres % 64] = res_domain;
      r_g[nres % 64]  = res_global;
      r_x[nres % 64]  = res_xn;
      r_w[nres % 64]  = res_write;
      r_f[nres % 64]  = res_fetch;
      nres++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  function automatic logic [31:0] l1addr(input logic [31:0] v);
    return {tbase, v[31:20], 2'b00};
  endfunction

  // one walk: push request, wait for its result; returns log index
  task automatic walk(input logic [31:0] v, input logic w, input logic f, output int idx);
    int start;
    start = nres;
    nrd = 0;
    nwr = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = v; req_write = w; req_fetch = f;
    @(negedge clk);
    req_valid = 1'b0;
    while (nres == start) @(negedge clk);
    idx = start % 64;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 res_valid", res_valid, 0);
  endtask

  task automatic t_section_af_set;
    int k;
    logic [31:0] v = 32'h1234_5678;
    a1 = l1addr(v); m1 = 32'hABC2_8CB2; a2 = 32'hFFFF_FFFF;
    walk(v, 1'b1, 1'b0, k);
    chk("R2 L1 read addr", rd_log[0], {tbase, 12'h123, 2'b00});
    chk("R2 reads", nrd, 1);
    chk("R3 paddr", r_pa[k], 32'hABC4_5678);
    chk("R3 perm", r_pm[k], 3'd7);
    chk("R3 xn", r_x[k], 1);
    chk("R3 global", r_g[k], 1);
    chk("R3 domain", r_dm[k], 4'd5);
    chk("R3 fcode", r_fc[k], 0);
    chk("R8 no write when flag set", nwr, 0);
    chk("R11 vaddr", r_va[k], v);
    chk("R11 write", r_w[k], 1);
    chk("R11 fetch", r_f[k], 0);
  endtask

  task automatic t_section_af_clear;
    int k;
    logic [31:0] v = 32'hFFF0_0010;
    a1 = l1addr(v); m1 = 32'h0010_0062;
    walk(v, 1'b0, 1'b1, k);
    chk("R8 one write", nwr, 1);
    chk("R8 write addr", wa_log[0], a1);
    chk("R8 write data", wd_log[0], 32'h0010_0462);
    chk("R8 perm has flag", r_pm[k], 3'b001);
    chk("R3 paddr", r_pa[k], 32'h0010_0010);
    chk("R3 global clear", r_g[k], 0);
    chk("R3 domain", r_dm[k], 4'd3);
    chk("R11 fetch", r_f[k], 1);
  endtask

  task automatic t_l1_faults;
    int k;
    logic [31:0] v = 32'h0230_0000;
    a1 = l1addr(v);
    m1 = 32'h1234_5000;
    walk(v, 1'b0, 1'b0, k);
    chk("R4 type0 fcode", r_fc[k], 1);
    chk("R4 type0 reads", nrd, 1);
    m1 = 32'h1234_5003;
    walk(v, 1'b0, 1'b0, k);
    chk("R4 type3 fcode", r_fc[k], 1);
    chk("R4 type3 reads", nrd, 1);
    m1 = 32'h0004_0002;
    walk(v, 1'b0, 1'b0, k);
    chk("R4 supersection fcode", r_fc[k], 2);
    chk("R4 supersection no write", nwr, 0);
    chk("R4 supersection reads", nrd, 1);
  endtask

  task automatic t_l2_small;
    int k;
    logic [31:0] v = 32'h0047_A123;
    a1 = l1addr(v); m1 = 32'h1234_5521;
    a2 = 32'h1234_55E8; m2 = 32'hCAFE_BA33;
    walk(v, 1'b0, 1'b0, k);
    chk("R5 reads", nrd, 2);
    chk("R5 L2 read addr", rd_log[1], 32'h1234_55E8);
    chk("R6 small paddr", r_pa[k], 32'hCAFE_B123);
    chk("R6 small xn", r_x[k], 1);
    chk("R6 perm", r_pm[k], 3'd7);
    chk("R6 global", r_g[k], 0);
    chk("R6 domain", r_dm[k], 4'd9);
    chk("R8 no write", nwr, 0);
  endtask

  task automatic t_l2_large_af;
    int k;
    logic [31:0] v = 32'h0047_A123;
    a1 = l1addr(v); m1 = 32'h1234_5521;
    a2 = 32'h1234_55E8; m2 = 32'h5555_8021;
    walk(v, 1'b0, 1'b0, k);
    chk("R6 large paddr", r_pa[k], 32'h5555_A123);
    chk("R6 large xn", r_x[k], 1);
    chk("R6 global", r_g[k], 1);
    chk("R8 perm has flag", r_pm[k], 3'b011);
    chk("R8 L2 write count", nwr, 1);
    chk("R8 L2 write addr", wa_log[0], 32'h1234_55E8);
    chk("R8 L2 write data", wd_log[0], 32'h5555_8031);
  endtask

  task automatic t_l2_invalid;
    int k;
    logic [31:0] v = 32'h0047_A123;
    a1 = l1addr(v); m1 = 32'h1234_5521;
    a2 = 32'h1234_55E8; m2 = 32'h5555_0000;
    walk(v, 1'b0, 1'b0, k);
    chk("R7 fcode", r_fc[k], 3);
    chk("R7 no write", nwr, 0);
  endtask

  task automatic t_queue;
    int acc, start, waited;
    acc = 0;
    start = nres;
    a1 = 32'hFFFF_FFFF; a2 = 32'hFFFF_FFFF;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (!req_ready) break;
      req_valid = 1'b1;
      req_vaddr = (i + 1) << 20;
      acc++;
    end
    req_valid = 1'b0;
    chk("R9 accepted while stalled", acc, 5);
    chk("R9 ready low when full", req_ready, 0);
    chk("R10 request held", mem_req_valid, 1);
    chk("R10 stalled addr", mem_req_addr, l1addr(32'h0010_0000));
    mem_req_ready = 1'b1;
    waited = 0;
    while (nres < start + 5 && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk("R9 results", nres - start, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R9 order", r_va[(start + i) % 64], (i + 1) << 20);
      chk("R9 fcode", r_fc[(start + i) % 64], 0);
    end
    chk("R9 ready restored", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_section_af_set;
    t_section_af_clear;
    t_l1_faults;
    t_l2_small;
    t_l2_large_af;
    t_l2_invalid;
    t_queue;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule